// File: doc/BRIEF.md
# Priority Dispatch Queue

This block is a shared work queue that stands in for processor interrupts in a symmetric multiprocessor. Event sources such as DMA engines, timers and software post small numeric priority codes into it instead of raising interrupts. Processors poll it when they reach a convenient point in their work. Each read hands back the largest code currently held and removes that one copy in the same operation. The code doubles as an index into a task table. Software chains work by posting the number of the next code strip of a task, and that strip runs once its number is the largest entry pending.

The queue holds up to `DEPTH` entries of `VAL_W` bits, and duplicates are kept as separate entries. Code 0 is reserved to mean "nothing pending". A read of an empty queue returns 0 with the empty flag set. A write into a full queue is lost and raises a sticky overflow flag. When a read and a write occur in the same cycle, the read chooses from the entries held before that write.

Top module: `prio_dispatch_queue`

## Requirements
- R1: During and right after a synchronous active-low reset, `level` is 0, `is_full` is 0, `lost_write` is 0, `pop_code` is 0 and `pop_none` is 1.
- R2: A write (`push_en`=1) of a nonzero `push_code` into a non-full queue adds one entry, so `level` is one higher after that clock edge.
- R3: A read (`pop_en`=1) of a non-empty queue presents the largest stored code on `pop_code` with `pop_none`=0 after that clock edge, and `level` drops by one at the same edge.
- R4: Equal codes are stored as separate entries, and each read removes exactly one copy.
- R5: A read of an empty queue gives `pop_code`=0 and `pop_none`=1, and leaves `level` at 0.
- R6: A write of code 0 is ignored: `level` does not change, and later reads never return it.
- R7: When `level` equals `DEPTH`, `is_full` is 1. A write that finds the queue full with no read in the same cycle is dropped. It leaves `level` and the stored codes unchanged and sets `lost_write`, which stays 1 until reset.
- R8: When a read and a write happen in the same cycle, the read returns the largest code held before the write, and `level` is unchanged. This also holds on a full queue, where the written code takes the freed place and `lost_write` is not set.
- R9: `pop_code` and `pop_none` keep their last values in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_en | input | 1 | Write strobe |
| push_code | input | VAL_W | Priority code to store (0 is ignored) |
| pop_en | input | 1 | Read strobe, which removes the largest entry |
| pop_code | output | VAL_W | Code returned by the most recent read |
| pop_none | output | 1 | The most recent read found the queue empty |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| is_full | output | 1 | Queue holds DEPTH entries |
| lost_write | output | 1 | Sticky: a write was dropped on a full queue |

## Verification
The bench posts duplicate maxima and reads them back one copy at a time. A design that merged duplicates would lose a dispatch, and one that removed every copy would report a level that is too low. It issues a read and a write together, both on a partly filled queue and on a full one. A design that let the new code bypass the comparison would return it too early, and one that refused the write at full would raise a false overflow. It then writes into a full queue, writes code 0, and reads an empty queue. The dropped code must never come back, and the empty read must yield 0 with the flag set rather than a stale slot value.

// File: rtl/pdq_pkg.sv
// Package: shared defaults and the per-cycle operation kind of the
// priority dispatch queue. Assumes nothing beyond IEEE 1800-2017.
package pdq_pkg;

    // Default sizing of the queue
    localparam int PDQ_DEPTH_DEF = 32;
    localparam int PDQ_VAL_W_DEF = 8;

    // What the queue does to its occupancy in one cycle
    typedef enum logic [1:0] {
        PDQ_OP_IDLE = 2'b00,
        PDQ_OP_PUSH = 2'b01,
        PDQ_OP_POP  = 2'b10,
        PDQ_OP_SWAP = 2'b11
    } pdq_op_e;

endpackage

// File: rtl/pdq_slot_bank.sv
// Module: pdq_slot_bank
// Holds DEPTH unordered code slots, each with a valid bit. In one cycle it
// can clear one slot (pop) and fill one slot (push). If both name the same
// slot, the fill wins, so a full queue can swap a code in place.
// Assumes that the caller only pushes into a free slot or into the slot
// being popped.
module pdq_slot_bank #(
    parameter int DEPTH = 32,
    parameter int VAL_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [IDX_W-1:0]       push_idx,
    input  logic [VAL_W-1:0]       push_val,
    input  logic                   pop,
    input  logic [IDX_W-1:0]       pop_idx,
    output logic [DEPTH-1:0]       slot_vld,
    output logic [DEPTH*VAL_W-1:0] slot_vals
);

    logic [VAL_W-1:0] vals_q [DEPTH];

    // Valid bits: the clear for a pop comes first, so a same-slot push overrides it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
        end else begin
            if (pop)  slot_vld[pop_idx]  <= 1'b0;
            if (push) slot_vld[push_idx] <= 1'b1;
        end
    end

    // Code storage: written only on a push, so it needs no reset
    always_ff @(posedge clk) begin
        if (push) vals_q[push_idx] <= push_val;
    end

    // Flatten the storage for the comparison tree
    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_flat
            assign slot_vals[s*VAL_W +: VAL_W] = vals_q[s];
        end
    endgenerate

endmodule

// File: rtl/pdq_max_tree.sv
// Module: pdq_max_tree
// Combinational tournament tree that finds the largest valid slot and its
// index. On ties the lower slot index wins.
// Assumes that DEPTH is a power of two and at least 2.
module pdq_max_tree #(
    parameter int DEPTH = 32,
    parameter int VAL_W = 8,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LEVELS = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]       slot_vld,
    input  logic [DEPTH*VAL_W-1:0] slot_vals,
    output logic                   any_vld,
    output logic [VAL_W-1:0]       max_val,
    output logic [IDX_W-1:0]       max_idx
);

    generate
        for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
            localparam int NODES = DEPTH >> lv;
            logic             nvld [NODES];
            logic [VAL_W-1:0] nval [NODES];
            logic [IDX_W-1:0] nidx [NODES];

            if (lv == 0) begin : g_leaf
                for (genvar n = 0; n < NODES; n++) begin : g_n
                    assign nvld[n] = slot_vld[n];
                    assign nval[n] = slot_vals[n*VAL_W +: VAL_W];
                    assign nidx[n] = IDX_W'(n);
                end
            end else begin : g_cmp
                for (genvar n = 0; n < NODES; n++) begin : g_n
                    logic take_left;
                    // Keep the left child when it is valid and not smaller
                    always_comb begin
                        take_left = g_lvl[lv-1].nvld[2*n] &&
                                    (!g_lvl[lv-1].nvld[2*n+1] ||
                                     (g_lvl[lv-1].nval[2*n] >= g_lvl[lv-1].nval[2*n+1]));
                    end
                    assign nvld[n] = g_lvl[lv-1].nvld[2*n] | g_lvl[lv-1].nvld[2*n+1];
                    assign nval[n] = take_left ? g_lvl[lv-1].nval[2*n] : g_lvl[lv-1].nval[2*n+1];
                    assign nidx[n] = take_left ? g_lvl[lv-1].nidx[2*n] : g_lvl[lv-1].nidx[2*n+1];
                end
            end
        end
    endgenerate

    assign any_vld = g_lvl[LEVELS].nvld[0];
    assign max_val = g_lvl[LEVELS].nval[0];
    assign max_idx = g_lvl[LEVELS].nidx[0];

endmodule

// File: rtl/pdq_free_finder.sv
// Module: pdq_free_finder
// Priority encoder that names the lowest-numbered empty slot.
// Assumes nothing about the slot contents.
module pdq_free_finder #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] slot_vld,
    output logic             has_free,
    output logic [IDX_W-1:0] free_idx
);

    // Scan from the top down, so the lowest free slot is the last match
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_vld[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_dispatch_queue.sv
// Module: prio_dispatch_queue
// Destructive-read max-priority queue used as the dispatch point in place of
// interrupts. A write stores a nonzero code. A read returns the largest stored
// code one clock later and removes that copy. A same-cycle read sees only the
// entries held before the write.
// Assumes that DEPTH is a power of two, that code 0 means "none", and that
// there is at most one writer and one reader per cycle.
module prio_dispatch_queue
    import pdq_pkg::*;
#(
    parameter int DEPTH = PDQ_DEPTH_DEF,
    parameter int VAL_W = PDQ_VAL_W_DEF,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [VAL_W-1:0] push_code,
    input  logic             pop_en,
    output logic [VAL_W-1:0] pop_code,
    output logic             pop_none,
    output logic [CNT_W-1:0] level,
    output logic             is_full,
    output logic             lost_write
);

    logic [DEPTH-1:0]       slot_vld;
    logic [DEPTH*VAL_W-1:0] slot_vals;
    logic                   any_vld;
    logic [VAL_W-1:0]       max_val;
    logic [IDX_W-1:0]       max_idx;
    logic                   has_free;
    logic [IDX_W-1:0]       free_idx;
    logic                   code_ok;
    logic                   do_pop;
    logic                   do_push;
    logic                   drop;
    logic [IDX_W-1:0]       push_idx;
    pdq_op_e                op;

    pdq_slot_bank #(.DEPTH(DEPTH), .VAL_W(VAL_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_idx  (push_idx),
        .push_val  (push_code),
        .pop       (do_pop),
        .pop_idx   (max_idx),
        .slot_vld  (slot_vld),
        .slot_vals (slot_vals)
    );

    pdq_max_tree #(.DEPTH(DEPTH), .VAL_W(VAL_W)) u_tree (
        .slot_vld  (slot_vld),
        .slot_vals (slot_vals),
        .any_vld   (any_vld),
        .max_val   (max_val),
        .max_idx   (max_idx)
    );

    pdq_free_finder #(.DEPTH(DEPTH)) u_free (
        .slot_vld  (slot_vld),
        .has_free  (has_free),
        .free_idx  (free_idx)
    );

    // Decide what this cycle does to the slots
    always_comb begin
        code_ok  = (push_code != '0);
        do_pop   = pop_en && any_vld;
        do_push  = push_en && code_ok && (has_free || do_pop);
        drop     = push_en && code_ok && !has_free && !do_pop;
        push_idx = has_free ? free_idx : max_idx;
        op       = pdq_op_e'({do_pop, do_push});
    end

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            unique case (op)
                PDQ_OP_PUSH: level <= level + 1'b1;
                PDQ_OP_POP:  level <= level - 1'b1;
                default:     level <= level;
            endcase
        end
    end

    // Read result registers, which hold between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_code <= '0;
            pop_none <= 1'b1;
        end else if (pop_en) begin
            pop_code <= any_vld ? max_val : '0;
            pop_none <= !any_vld;
        end
    end

    // Sticky flag for a write lost to a full queue
    always_ff @(posedge clk) begin
        if (!rst_n) lost_write <= 1'b0;
        else if (drop) lost_write <= 1'b1;
    end

    assign is_full = (level == CNT_W'(DEPTH));

endmodule

// File: rtl/pdq_checker.sv
// Module: pdq_checker
// Port-level temporal checks on prio_dispatch_queue, bound into every
// instance. Assumes the same parameters as the bound instance.
module pdq_checker #(
    parameter int DEPTH = 32,
    parameter int VAL_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_en,
    input logic [VAL_W-1:0] push_code,
    input logic             pop_en,
    input logic [VAL_W-1:0] pop_code,
    input logic             pop_none,
    input logic [CNT_W-1:0] level,
    input logic             is_full,
    input logic             lost_write
);

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && level == '0) |=> (pop_none && pop_code == '0 && level == '0));

    assert_read_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en && level != '0) |=> (!pop_none && pop_code != '0 && level == $past(level) - 1'b1));

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_code != '0 && !pop_en && !is_full) |=> (level == $past(level) + 1'b1));

    assert_zero_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_code == '0 && !pop_en) |=> $stable(level));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_code != '0 && !pop_en && is_full) |=> (lost_write && $stable(level)));

    assert_sticky_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost_write |=> lost_write);

    assert_swap_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_code != '0 && pop_en && level != '0) |=> $stable(level));

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_en |=> ($stable(pop_code) && $stable(pop_none)));

endmodule

bind prio_dispatch_queue pdq_checker #(.DEPTH(DEPTH), .VAL_W(VAL_W)) u_pdq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (push_en),
    .push_code  (push_code),
    .pop_en     (pop_en),
    .pop_code   (pop_code),
    .pop_none   (pop_none),
    .level      (level),
    .is_full    (is_full),
    .lost_write (lost_write)
);

// File: tb/prio_dispatch_queue_tb.sv
// Bench for prio_dispatch_queue: a vector table, then directed corner tests.
module prio_dispatch_queue_tb;

    localparam int DEPTH = 32;
    localparam int VAL_W = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NVEC  = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_en = 1'b0;
    logic [VAL_W-1:0] push_code = '0;
    logic             pop_en = 1'b0;
    logic [VAL_W-1:0] pop_code;
    logic             pop_none;
    logic [CNT_W-1:0] level;
    logic             is_full;
    logic             lost_write;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    prio_dispatch_queue #(.DEPTH(DEPTH), .VAL_W(VAL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_code(push_code),
        .pop_en(pop_en), .pop_code(pop_code), .pop_none(pop_none),
        .level(level), .is_full(is_full), .lost_write(lost_write)
    );

    // Row: {push_en, push_code, pop_en, exp_code, exp_none, exp_level}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'd5,   1'b0, 8'd0,   1'b0, 6'd1},
        {1'b1, 8'd200, 1'b0, 8'd0,   1'b0, 6'd2},
        {1'b1, 8'd17,  1'b0, 8'd0,   1'b0, 6'd3},
        {1'b1, 8'd200, 1'b0, 8'd0,   1'b0, 6'd4},   // duplicate, R4
        {1'b0, 8'd0,   1'b1, 8'd200, 1'b0, 6'd3},
        {1'b0, 8'd0,   1'b1, 8'd200, 1'b0, 6'd2},   // second copy, R4
        {1'b1, 8'd99,  1'b1, 8'd17,  1'b0, 6'd2},   // swap sees old set, R8
        {1'b0, 8'd0,   1'b1, 8'd99,  1'b0, 6'd1},
        {1'b0, 8'd0,   1'b1, 8'd5,   1'b0, 6'd0},
        {1'b0, 8'd0,   1'b1, 8'd0,   1'b1, 6'd0},   // empty read, R5
        {1'b1, 8'd0,   1'b0, 8'd0,   1'b0, 6'd0},   // zero write, R6
        {1'b1, 8'd255, 1'b0, 8'd0,   1'b0, 6'd1},
        {1'b0, 8'd0,   1'b1, 8'd255, 1'b0, 6'd0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample at the next falling edge
    task automatic step(input logic w, input logic [VAL_W-1:0] c, input logic r);
        push_en = w; push_code = c; pop_en = r;
        @(posedge clk);
        @(negedge clk);
        push_en = 1'b0; push_code = '0; pop_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", "level", int'(level), 0);
        check("R1", "pop_none", int'(pop_none), 1);
        check("R1", "pop_code", int'(pop_code), 0);
        check("R1", "lost_write", int'(lost_write), 0);
        check("R1", "is_full", int'(is_full), 0);

        // Vector table: R2 level after writes, R3 value after reads
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][24], VEC[i][23:16], VEC[i][15]);
            check("R2", $sformatf("row %0d level", i), int'(level), int'(VEC[i][5:0]));
            if (VEC[i][15]) begin
                check("R3", $sformatf("row %0d code", i), int'(pop_code), int'(VEC[i][14:7]));
                check("R5", $sformatf("row %0d none", i), int'(pop_none), int'(VEC[i][6]));
            end
        end

        // R7 fill to capacity with codes 1..DEPTH
        for (int i = 1; i <= DEPTH; i++) step(1'b1, VAL_W'(i), 1'b0);
        check("R7", "level at full", int'(level), DEPTH);
        check("R7", "is_full", int'(is_full), 1);

        // R8 swap on a full queue: old max returned, no loss
        step(1'b1, 8'd150, 1'b1);
        check("R8", "full swap code", int'(pop_code), DEPTH);
        check("R8", "full swap level", int'(level), DEPTH);
        check("R8", "full swap no loss", int'(lost_write), 0);
        step(1'b0, 8'd0, 1'b1);
        check("R8", "swapped code kept", int'(pop_code), 150);
        step(1'b1, 8'd33, 1'b0);
        check("R7", "refill level", int'(level), DEPTH);

        // R7 write into full queue is dropped and flagged
        step(1'b1, 8'd100, 1'b0);
        check("R7", "lost_write set", int'(lost_write), 1);
        check("R7", "level unchanged", int'(level), DEPTH);
        step(1'b0, 8'd0, 1'b1);
        check("R7", "dropped code absent", int'(pop_code), 33);
        step(1'b0, 8'd0, 1'b0);
        check("R7", "lost_write sticky", int'(lost_write), 1);

        // R9 outputs hold across idle cycles
        step(1'b0, 8'd0, 1'b0);
        check("R9", "hold code", int'(pop_code), 33);
        check("R9", "hold none", int'(pop_none), 0);

        // R1 reset clears the sticky flag and contents
        do_reset();
        check("R1", "lost_write cleared", int'(lost_write), 0);
        check("R1", "level cleared", int'(level), 0);

        // R6 zero write then read: still empty
        step(1'b1, 8'd0, 1'b0);
        step(1'b0, 8'd0, 1'b1);
        check("R6", "zero not stored", int'(pop_none), 1);
        check("R5", "empty code", int'(pop_code), 0);

        // R4 three equal codes leave one at a time
        for (int i = 0; i < 3; i++) step(1'b1, 8'd42, 1'b0);
        for (int i = 2; i >= 0; i--) begin
            step(1'b0, 8'd0, 1'b1);
            check("R4", "dup code", int'(pop_code), 42);
            check("R4", "dup level", int'(level), i);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule